// File: doc/BRIEF.md
# One-Shot Prescaled Down-Counter Timer

This block is an 8-bit single-shot interval timer for a small microcontroller. Software writes the preset value in two 4-bit halves, each through its own write strobe. It then sets the run bit in a 4-bit mode register. The count steps down once per prescaled period. When it passes zero and wraps to FFh, the timer halts itself, clears its run bit and raises a sticky event flag. The prescaled period is either a fast or a slow division of the block clock, chosen by a rate bit in the mode register.

The event flag drives two outputs. An interrupt request is the flag gated by an interrupt-enable input. A wake request is the flag gated by a hold-release-enable input; it is meant for an external power controller. The flag stays set until a flag-clear strobe arrives or until the next start. The time from the start edge to the flag edge is (preset + 1) × divider clock cycles. The divider restarts on every start, so the first period is always a whole one.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the count reads 00h, all mode bits read 0 (run bit 3 clear, rate bit 0 fast), and the event flag, interrupt request and wake request are 0.
- R2: A low-nibble strobe loads wr_data into count bits 3:0, and a high-nibble strobe loads wr_data into count bits 7:4. The other nibble is left unchanged.
- R3: A write to either nibble stops a running count and clears mode bit 3 in the next cycle. A nibble write in the same cycle as a mode write that sets bit 3 leaves the timer stopped.
- R4: A mode write with bit 3 = 1, while the timer is stopped, starts it and clears the event flag in the same clock edge.
- R5: With mode bit 0 = 0, the event flag rises exactly (preset + 1) × FAST_DIV cycles after the start edge. The count reads 00h one cycle before that.
- R6: With mode bit 0 = 1, the same interval uses SLOW_DIV in place of FAST_DIV.
- R7: On underflow the count becomes FFh and mode bit 3 returns to 0. The count then holds FFh until the next nibble write.
- R8: irq equals the event flag AND irq_en. wake equals the event flag AND wake_en.
- R9: An evt_clr pulse (a flag-clear write with mask bit 1) clears a set event flag on the next edge. Without a clear or a start, the flag stays set.
- R10: If an underflow and an evt_clr pulse fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the oscillator) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Low-nibble preset write strobe |
| wr_hi | input | 1 | High-nibble preset write strobe |
| wr_data | input | NIB_W | Nibble value for a preset write |
| mode_wr | input | 1 | Mode register write strobe |
| mode_data | input | 4 | Mode value: bit 3 run, bit 0 rate (1 = slow) |
| evt_clr | input | 1 | Event flag clear (flag-clear write with mask bit 1) |
| irq_en | input | 1 | Interrupt enable for the timer event |
| wake_en | input | 1 | Hold-release enable for the timer event |
| count_q | output | 2*NIB_W | Present counter value |
| mode_q | output | 4 | Mode register readback |
| evt_q | output | 1 | Timer event flag |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Hold-release (wake) request |

## Verification
Two functions can collide in one cycle: the underflow that sets the event flag, and a software clear that resets it. The bench starts a count from a known preset and counts the cycles to the underflow edge. It raises evt_clr in exactly the cycle before that edge, so that both act on the same edge, and then requires the flag to read 1. A second coincidence gets the same treatment. A nibble write and a run-setting mode write are issued together, and the bench checks that the timer stays stopped and the loaded value does not move.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  localparam int MODE_W   = 4;
  localparam int RUN_BIT  = 3;
  localparam int RATE_BIT = 0;

  // Last prescaler state of one count period for the chosen rate.
  function automatic int unsigned rate_last(input rate_e r,
                                            input int unsigned slow_div,
                                            input int unsigned fast_div);
    return (r == RATE_SLOW) ? slow_div - 1 : fast_div - 1;
  endfunction

  // Cycles from start edge to underflow edge.
  function automatic int unsigned shot_cycles(input int unsigned preset,
                                              input int unsigned div);
    return (preset + 1) * div;
  endfunction

endpackage

// File: rtl/tm_prescaler.sv
module tm_prescaler
  import tm_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 1024,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_i,
  input  logic  restart_i,
  input  rate_e rate_i,
  output logic  tick_o
);

  localparam int PRE_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(rate_last(RATE_SLOW, SLOW_DIV, FAST_DIV));
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(rate_last(RATE_FAST, SLOW_DIV, FAST_DIV));

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last_w;

  assign last_w = (rate_i == RATE_SLOW) ? SLOW_LAST : FAST_LAST;
  // Compare with >= so a rate change mid-period cannot skip the wrap.
  assign tick_o = run_i & (pre_q >= last_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart_i || !run_i || tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/tm_counter.sv
module tm_counter #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo_i,
  input  logic               wr_hi_i,
  input  logic [NIB_W-1:0]   wr_data_i,
  input  logic               tick_i,
  output logic [2*NIB_W-1:0] count_o,
  output logic               nib_wr_o,
  output logic               underflow_o
);

  localparam int LANES = 2;
  localparam int CW    = LANES * NIB_W;

  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return v - 1'b1;
  endfunction

  logic [CW-1:0]    count_q;
  logic [CW-1:0]    load_val;
  logic [LANES-1:0] lane_we;

  assign lane_we  = {wr_hi_i, wr_lo_i};
  assign nib_wr_o = |lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign load_val[g*NIB_W +: NIB_W] =
      lane_we[g] ? wr_data_i : count_q[g*NIB_W +: NIB_W];
  end

  // A nibble write suppresses an underflow in the same cycle.
  assign underflow_o = tick_i & (count_q == '0) & ~nib_wr_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (nib_wr_o) begin
      count_q <= load_val;
    end else if (tick_i) begin
      count_q <= step_down(count_q);
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/tm_mode_ctrl.sv
module tm_mode_ctrl
  import tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_data_i,
  input  logic              nib_wr_i,
  input  logic              underflow_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              run_o,
  output rate_e             rate_o,
  output logic              start_o
);

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] mode_nxt;

  assign start_o = mode_wr_i & mode_data_i[RUN_BIT] & ~mode_q[RUN_BIT] & ~nib_wr_i;

  always_comb begin
    mode_nxt = mode_wr_i ? mode_data_i : mode_q;
    if (nib_wr_i || underflow_i) begin
      mode_nxt[RUN_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      mode_q <= mode_nxt;
    end
  end

  assign mode_o = mode_q;
  assign run_o  = mode_q[RUN_BIT];
  assign rate_o = rate_e'(mode_q[RATE_BIT]);

endmodule

// File: rtl/tm_event.sv
module tm_event (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic underflow_i,
  input  logic clr_i,
  input  logic irq_en_i,
  input  logic wake_en_i,
  output logic evt_o,
  output logic irq_o,
  output logic wake_o
);

  logic evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
    end else if (underflow_i) begin
      evt_q <= 1'b1;
    end else if (start_i || clr_i) begin
      evt_q <= 1'b0;
    end
  end

  assign evt_o  = evt_q;
  assign irq_o  = evt_q & irq_en_i;
  assign wake_o = evt_q & wake_en_i;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import tm_pkg::*;
#(
  parameter int          NIB_W    = 4,
  parameter int unsigned SLOW_DIV = 1024,
  parameter int unsigned FAST_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [NIB_W-1:0]     wr_data,
  input  logic                 mode_wr,
  input  logic [3:0]           mode_data,
  input  logic                 evt_clr,
  input  logic                 irq_en,
  input  logic                 wake_en,
  output logic [2*NIB_W-1:0]   count_q,
  output logic [3:0]           mode_q,
  output logic                 evt_q,
  output logic                 irq,
  output logic                 wake
);

  // Internal events, named for the checker.
  logic  start_evt;
  logic  tick_evt;
  logic  underflow_evt;
  logic  nib_wr;
  logic  run_w;
  rate_e rate_w;

  tm_counter #(.NIB_W(NIB_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lo_i    (wr_lo),
    .wr_hi_i    (wr_hi),
    .wr_data_i  (wr_data),
    .tick_i     (tick_evt),
    .count_o    (count_q),
    .nib_wr_o   (nib_wr),
    .underflow_o(underflow_evt)
  );

  tm_mode_ctrl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr_i  (mode_wr),
    .mode_data_i(mode_data),
    .nib_wr_i   (nib_wr),
    .underflow_i(underflow_evt),
    .mode_o     (mode_q),
    .run_o      (run_w),
    .rate_o     (rate_w),
    .start_o    (start_evt)
  );

  tm_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (run_w),
    .restart_i(start_evt),
    .rate_i   (rate_w),
    .tick_o   (tick_evt)
  );

  tm_event u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_evt),
    .underflow_i(underflow_evt),
    .clr_i      (evt_clr),
    .irq_en_i   (irq_en),
    .wake_en_i  (wake_en),
    .evt_o      (evt_q),
    .irq_o      (irq),
    .wake_o     (wake)
  );

endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_lo,
  input logic          wr_hi,
  input logic          evt_clr,
  input logic          start_evt,
  input logic          tick_evt,
  input logic          underflow_evt,
  input logic          run,
  input logic [CW-1:0] count_q,
  input logic          evt_q,
  input logic          wake
);

  AST_UNDERFLOW_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |=> (!run && count_q == '1 && evt_q)); // R7

  AST_NIBBLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo || wr_hi) |=> !run); // R3

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run && !evt_q)); // R4

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |-> run); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_evt && !wr_lo && !wr_hi) |=> count_q == CW'($past(count_q) - 1'b1)); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_lo && !wr_hi) |=> $stable(count_q)); // R7

  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> evt_q); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && !underflow_evt) |=> !evt_q); // R9

  AST_UNDERFLOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr && underflow_evt) |=> evt_q); // R10

endmodule

bind oneshot_timer oneshot_timer_chk #(.CW(2*NIB_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_lo        (wr_lo),
  .wr_hi        (wr_hi),
  .evt_clr      (evt_clr),
  .start_evt    (start_evt),
  .tick_evt     (tick_evt),
  .underflow_evt(underflow_evt),
  .run          (run_w),
  .count_q      (count_q),
  .evt_q        (evt_q),
  .wake         (wake)
);

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;

  localparam int NW   = 4;
  localparam int CW   = 2 * NW;
  localparam int SLOW = 16;
  localparam int FAST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_lo = 1'b0, wr_hi = 1'b0;
  logic [NW-1:0] wr_data = '0;
  logic          mode_wr = 1'b0;
  logic [3:0]    mode_data = '0;
  logic          evt_clr = 1'b0, irq_en = 1'b0, wake_en = 1'b0;
  logic [CW-1:0] count_q;
  logic [3:0]    mode_q;
  logic          evt_q, irq, wake;

  always #4 clk = ~clk;

  oneshot_timer #(.NIB_W(NW), .SLOW_DIV(SLOW), .FAST_DIV(FAST)) uut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .mode_wr(mode_wr), .mode_data(mode_data), .evt_clr(evt_clr),
    .irq_en(irq_en), .wake_en(wake_en), .count_q(count_q), .mode_q(mode_q),
    .evt_q(evt_q), .irq(irq), .wake(wake)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int v);
    @(negedge clk); wr_lo = 1'b1; wr_data = NW'(v);
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = NW'(v >> NW);
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_data = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  // Load, start, and time the shot against (p+1)*div.
  task automatic shot(input int p, input bit slow);
    int div = slow ? SLOW : FAST;
    load(p);
    set_mode(slow ? 4'h9 : 4'h8);
    check("R4 flag cleared by start", int'(evt_q), 0);
    check("R4 run bit set", int'(mode_q[3]), 1);
    repeat ((p + 1) * div - 1) @(posedge clk);
    @(negedge clk);
    check(slow ? "R6 flag low before interval" : "R5 flag low before interval", int'(evt_q), 0);
    check("R5 count zero one cycle before", int'(count_q), 0);
    @(negedge clk);
    check(slow ? "R6 flag at interval" : "R5 flag at interval", int'(evt_q), 1);
    check("R7 count wraps to FFh", int'(count_q), 255);
    check("R7 run bit self-cleared", int'(mode_q[3]), 0);
    check("R8 irq gating", int'(irq), int'(evt_q & irq_en));
    check("R8 wake gating", int'(wake), int'(evt_q & wake_en));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R6 reset state
    check("R1 count reset", int'(count_q), 0);
    check("R1 mode reset", int'(mode_q), 0);
    check("R6 default fast rate", int'(mode_q[0]), 0);
    check("R1 flag reset", int'(evt_q), 0);
    check("R1 irq reset", int'(irq), 0);
    check("R1 wake reset", int'(wake), 0);

    // R2 nibble loads
    load(8'hA5);
    check("R2 both nibbles", int'(count_q), 8'hA5);
    @(negedge clk); wr_lo = 1'b1; wr_data = 4'h3;
    @(negedge clk); wr_lo = 1'b0;
    check("R2 low nibble only", int'(count_q), 8'hA3);
    @(negedge clk); wr_hi = 1'b1; wr_data = 4'h6;
    @(negedge clk); wr_hi = 1'b0;
    check("R2 high nibble only", int'(count_q), 8'h63);

    // R5 exhaustive preset sweep at the fast rate, R8 enables varied
    for (int p = 0; p < 256; p++) begin
      irq_en  = p[0];
      wake_en = p[1];
      shot(p, 1'b0);
    end

    // R6 slow rate
    for (int k = 0; k < 3; k++) begin
      shot((k == 0) ? 0 : (k == 1) ? 3 : 200, 1'b1);
      check("R6 rate bit reads 1", int'(mode_q[0]), 1);
    end

    // R7 hold after self-stop, R9 flag persists
    repeat (20) @(negedge clk);
    check("R7 count holds FFh", int'(count_q), 255);
    check("R9 flag persists", int'(evt_q), 1);

    // R8 direct gating
    @(negedge clk); irq_en = 1'b1; wake_en = 1'b0; #1;
    check("R8 irq on", int'(irq), 1);
    check("R8 wake off", int'(wake), 0);
    @(negedge clk); irq_en = 1'b0; wake_en = 1'b1; #1;
    check("R8 irq off", int'(irq), 0);
    check("R8 wake on", int'(wake), 1);

    // R9 clear
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    check("R9 flag cleared", int'(evt_q), 0);
    check("R9 wake dropped", int'(wake), 0);

    // R3 nibble write halts a running count
    load(8'h50);
    set_mode(4'h8);
    repeat (10) @(negedge clk);
    @(negedge clk); c0 = int'(count_q); wr_hi = 1'b1; wr_data = 4'h2;
    @(negedge clk); wr_hi = 1'b0;
    check("R3 run cleared by nibble write", int'(mode_q[3]), 0);
    check("R3 loaded nibble", int'(count_q), (2 << 4) | (c0 & 15));
    repeat (30) @(negedge clk);
    check("R3 count frozen", int'(count_q), (2 << 4) | (c0 & 15));
    check("R3 no event", int'(evt_q), 0);

    // R3 nibble write beats a same-cycle start
    @(negedge clk); wr_lo = 1'b1; wr_data = 4'h1; mode_wr = 1'b1; mode_data = 4'h8;
    @(negedge clk); wr_lo = 1'b0; mode_wr = 1'b0;
    check("R3 start suppressed", int'(mode_q[3]), 0);
    repeat (20) @(negedge clk);
    check("R3 value unmoved", int'(count_q), (2 << 4) | 1);

    // R10 clear and underflow on the same edge
    load(2);
    set_mode(4'h8);
    repeat (3 * FAST - 1) @(posedge clk);
    @(negedge clk); evt_clr = 1'b1;
    @(negedge clk); evt_clr = 1'b0;
    check("R10 underflow wins", int'(evt_q), 1);
    check("R10 count wrapped", int'(count_q), 255);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule